// File: doc/BRIEF.md
# Dual-Loop Programmable Divider Chain

This block turns one reference oscillator and two RF feedback inputs into the comparison pulse trains needed by two phase-locked loops, one for transmit and one for receive. Each loop owns a main reference divider fed from the shared oscillator, so the two loops can run at different comparison frequencies. An extra auxiliary reference divider, also fed from the oscillator, can stand in for both main reference dividers. Each loop also owns a 16-bit feedback divider clocked by its RF input. A companion clock for a host processor is made by dividing the oscillator by three or by four.

All logic runs on one system clock. The oscillator and the two RF inputs are presented as single-cycle count enables (`osc_tick`, `tx_rf_tick`, `rx_rf_tick`). Divide ratios, enables and sleep controls come as static levels from a separate serial loader. Every divider output is a one-clock pulse that goes to a phase detector outside this block.

Top module: `dual_loop_divider`

## Requirements
- R1: While `rst_n` is low, all four pulse outputs and `mcu_clk_out` are 0.
- R2: With `use_aux_ref`=0, `tx_cmp_pulse` and `rx_cmp_pulse` each fire once every N `osc_tick` cycles. N is the loop's own 12-bit reference ratio, legal from 16 to 4095. The two loops run independently of each other.
- R3: `tx_fb_pulse` fires once every N `tx_rf_tick` cycles, and `rx_fb_pulse` once every N `rx_rf_tick` cycles. N is that loop's 16-bit feedback ratio, legal from 16 to 65535.
- R4: With `use_aux_ref`=1 and `aux_enable`=1, both comparison outputs follow the auxiliary divider. It fires once every M `osc_tick` cycles, where M is the 14-bit `aux_ratio`, from 16 to 16383.
- R5: With `aux_enable`=0 the auxiliary divider is held static with its output low, so with `use_aux_ref`=1 neither comparison output pulses. When `aux_enable` returns to 1, the first auxiliary pulse comes after a full M ticks counted from the first tick it sees.
- R6: Any programmed ratio below 16 divides by exactly 16.
- R7: A ratio change takes effect only at the next terminal count. The period in progress completes with the old ratio, and later periods use the new one.
- R8: Each pulse is exactly one clock wide. A pulse appears only in the clock after an edge at which the divider's count enable was 1.
- R9: `tx_sleep` (or `rx_sleep`) holds that loop's reference and feedback dividers in reset with both of its outputs low, while the other loop keeps running. After release, the first pulse comes after a full period.
- R10: `mcu_clk_out` steps through a count of `osc_tick` cycles. With `mcu_ratio4`=0 it is high one cycle in three; with `mcu_ratio4`=1 it is high two cycles in four. A new ratio applies from the next wrap of the count, and the output holds its value while `osc_tick` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| osc_tick | input | 1 | Count enable from the reference oscillator |
| tx_rf_tick | input | 1 | Count enable from the transmit RF input |
| rx_rf_tick | input | 1 | Count enable from the receive RF input |
| tx_ref_ratio | input | 12 | Transmit main reference ratio |
| rx_ref_ratio | input | 12 | Receive main reference ratio |
| aux_ratio | input | 14 | Auxiliary reference ratio |
| aux_enable | input | 1 | 1 runs the auxiliary divider, 0 holds it powered down |
| use_aux_ref | input | 1 | 1 takes both comparison outputs from the auxiliary divider |
| tx_fb_ratio | input | 16 | Transmit feedback ratio |
| rx_fb_ratio | input | 16 | Receive feedback ratio |
| tx_sleep | input | 1 | Holds the transmit loop dividers in reset |
| rx_sleep | input | 1 | Holds the receive loop dividers in reset |
| mcu_ratio4 | input | 1 | Companion clock ratio: 0 divides by 3, 1 divides by 4 |
| tx_cmp_pulse | output | 1 | Transmit comparison pulse |
| rx_cmp_pulse | output | 1 | Receive comparison pulse |
| tx_fb_pulse | output | 1 | Transmit feedback pulse |
| rx_fb_pulse | output | 1 | Receive feedback pulse |
| mcu_clk_out | output | 1 | Companion clock output |

## Verification
The hardest case to reach is a ratio change in the middle of a period. The new value must not touch the period already in progress. The stimulus releases a loop with one ratio, waits a few cycles, and then writes a different ratio. The scoreboard then expects one interval at the old ratio followed by intervals at the new one. Intervals are counted in enabled ticks rather than clocks, so the same check also covers a gated RF enable, an auxiliary divider restarted from its power-down state, and one loop asleep while the other keeps producing pulses.

// File: rtl/dld_pkg.sv
package dld_pkg;
   // smallest divide ratio any counter will use
   localparam int unsigned MIN_RATIO = 16;
   // loop indices
   localparam int unsigned NUM_LOOPS = 2;
   localparam int unsigned LOOP_TX   = 0;
   localparam int unsigned LOOP_RX   = 1;

   typedef enum logic {
      MCU_DIV3 = 1'b0,
      MCU_DIV4 = 1'b1
   } mcu_ratio_e;
endpackage

// File: rtl/dld_prog_divider.sv
module dld_prog_divider #(
   parameter int unsigned W     = 12,
   parameter int unsigned FLOOR = dld_pkg::MIN_RATIO
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         tick,
   input  logic         hold,
   input  logic [W-1:0] ratio,
   output logic         pulse
);
   localparam logic [W-1:0] FLOOR_V = W'(FLOOR);
   localparam logic [W-1:0] ONE_V   = W'(1);

   if (FLOOR < 2 || FLOOR >= (1 << W)) begin : g_floor_chk
      $error("dld_prog_divider: FLOOR must lie in 2 .. 2**W-1");
   end

   logic [W-1:0] eff_ratio;
   logic [W-1:0] lim_q;
   logic [W-1:0] cnt_q;
   logic         fresh_q;
   logic [W-1:0] limit;

   // ratios under the floor are raised to it
   assign eff_ratio = (ratio < FLOOR_V) ? FLOOR_V : ratio;
   // first period after release takes the live ratio, later ones the latched one
   assign limit     = fresh_q ? eff_ratio : lim_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q   <= '0;
         lim_q   <= FLOOR_V;
         fresh_q <= 1'b1;
         pulse   <= 1'b0;
      end else if (hold) begin
         cnt_q   <= '0;
         fresh_q <= 1'b1;
         pulse   <= 1'b0;
      end else if (tick) begin
         if (fresh_q) begin
            lim_q   <= eff_ratio;
            fresh_q <= 1'b0;
         end
         if (cnt_q == limit - ONE_V) begin
            cnt_q <= '0;
            lim_q <= eff_ratio;
            pulse <= 1'b1;
         end else begin
            cnt_q <= cnt_q + ONE_V;
            pulse <= 1'b0;
         end
      end else begin
         pulse <= 1'b0;
      end
   end
endmodule

// File: rtl/dld_mcu_clkdiv.sv
module dld_mcu_clkdiv (
   input  logic clk,
   input  logic rst_n,
   input  logic tick,
   input  logic ratio4,
   output logic clk_out
);
   import dld_pkg::*;

   mcu_ratio_e sel_q;
   logic [1:0] phase_q;
   logic [1:0] last_phase;

   assign last_phase = (sel_q == MCU_DIV4) ? 2'd3 : 2'd2;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q <= 2'd0;
         sel_q   <= MCU_DIV3;
      end else if (tick) begin
         if (phase_q == last_phase) begin
            phase_q <= 2'd0;
            sel_q   <= mcu_ratio_e'(ratio4);
         end else begin
            phase_q <= phase_q + 2'd1;
         end
      end
   end

   // high for phases 2 and 3: one of three, or two of four
   assign clk_out = phase_q[1];
endmodule

// File: rtl/dual_loop_divider.sv
module dual_loop_divider #(
   parameter int unsigned REF_W     = 12,
   parameter int unsigned AUX_W     = 14,
   parameter int unsigned FB_W      = 16,
   parameter int unsigned MIN_RATIO = dld_pkg::MIN_RATIO
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             osc_tick,
   input  logic             tx_rf_tick,
   input  logic             rx_rf_tick,
   input  logic [REF_W-1:0] tx_ref_ratio,
   input  logic [REF_W-1:0] rx_ref_ratio,
   input  logic [AUX_W-1:0] aux_ratio,
   input  logic             aux_enable,
   input  logic             use_aux_ref,
   input  logic [FB_W-1:0]  tx_fb_ratio,
   input  logic [FB_W-1:0]  rx_fb_ratio,
   input  logic             tx_sleep,
   input  logic             rx_sleep,
   input  logic             mcu_ratio4,
   output logic             tx_cmp_pulse,
   output logic             rx_cmp_pulse,
   output logic             tx_fb_pulse,
   output logic             rx_fb_pulse,
   output logic             mcu_clk_out
);
   import dld_pkg::*;

   localparam int unsigned FLOOR_BITS = $clog2(MIN_RATIO + 1);

   if (REF_W < FLOOR_BITS || AUX_W < FLOOR_BITS || FB_W < FLOOR_BITS) begin : g_width_chk
      $error("dual_loop_divider: a ratio width cannot hold MIN_RATIO");
   end

   logic                 aux_pulse;
   logic [NUM_LOOPS-1:0] loop_sleep;
   logic [NUM_LOOPS-1:0] loop_rf_tick;
   logic [NUM_LOOPS-1:0] ref_pulse;
   logic [NUM_LOOPS-1:0] fb_pulse;
   logic [NUM_LOOPS-1:0] cmp_pulse;
   logic [REF_W-1:0]     ref_ratio [NUM_LOOPS];
   logic [FB_W-1:0]      fb_ratio  [NUM_LOOPS];

   assign loop_sleep[LOOP_TX]   = tx_sleep;
   assign loop_sleep[LOOP_RX]   = rx_sleep;
   assign loop_rf_tick[LOOP_TX] = tx_rf_tick;
   assign loop_rf_tick[LOOP_RX] = rx_rf_tick;
   assign ref_ratio[LOOP_TX]    = tx_ref_ratio;
   assign ref_ratio[LOOP_RX]    = rx_ref_ratio;
   assign fb_ratio[LOOP_TX]     = tx_fb_ratio;
   assign fb_ratio[LOOP_RX]     = rx_fb_ratio;

   // auxiliary reference, powered down (held) when not enabled
   dld_prog_divider #(.W(AUX_W), .FLOOR(MIN_RATIO)) u_aux (
      .clk   (clk),
      .rst_n (rst_n),
      .tick  (osc_tick),
      .hold  (!aux_enable),
      .ratio (aux_ratio),
      .pulse (aux_pulse)
   );

   for (genvar li = 0; li < NUM_LOOPS; li++) begin : g_loop
      dld_prog_divider #(.W(REF_W), .FLOOR(MIN_RATIO)) u_ref (
         .clk   (clk),
         .rst_n (rst_n),
         .tick  (osc_tick),
         .hold  (loop_sleep[li]),
         .ratio (ref_ratio[li]),
         .pulse (ref_pulse[li])
      );
      dld_prog_divider #(.W(FB_W), .FLOOR(MIN_RATIO)) u_fb (
         .clk   (clk),
         .rst_n (rst_n),
         .tick  (loop_rf_tick[li]),
         .hold  (loop_sleep[li]),
         .ratio (fb_ratio[li]),
         .pulse (fb_pulse[li])
      );
      assign cmp_pulse[li] = !loop_sleep[li] & (use_aux_ref ? aux_pulse : ref_pulse[li]);
   end

   dld_mcu_clkdiv u_mcu (
      .clk     (clk),
      .rst_n   (rst_n),
      .tick    (osc_tick),
      .ratio4  (mcu_ratio4),
      .clk_out (mcu_clk_out)
   );

   assign tx_cmp_pulse = cmp_pulse[LOOP_TX];
   assign rx_cmp_pulse = cmp_pulse[LOOP_RX];
   assign tx_fb_pulse  = fb_pulse[LOOP_TX];
   assign rx_fb_pulse  = fb_pulse[LOOP_RX];
endmodule

// File: rtl/dld_chk.sv
module dld_chk (
   input logic clk,
   input logic rst_n,
   input logic osc_tick,
   input logic tx_rf_tick,
   input logic rx_rf_tick,
   input logic aux_enable,
   input logic use_aux_ref,
   input logic tx_sleep,
   input logic rx_sleep,
   input logic aux_pulse,
   input logic tx_cmp_pulse,
   input logic rx_cmp_pulse,
   input logic tx_fb_pulse,
   input logic rx_fb_pulse,
   input logic mcu_clk_out
);
   // R8
   tx_fb_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tx_fb_pulse |=> !tx_fb_pulse);
   // R8
   rx_fb_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rx_fb_pulse |=> !rx_fb_pulse);
   // R8
   tx_fb_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !tx_rf_tick |=> !tx_fb_pulse);
   // R8
   rx_fb_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !rx_rf_tick |=> !rx_fb_pulse);
   // R9
   tx_sleep_fb_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tx_sleep && $past(tx_sleep) |-> !tx_fb_pulse);
   // R9
   rx_sleep_fb_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rx_sleep && $past(rx_sleep) |-> !rx_fb_pulse);
   // R5
   aux_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !aux_enable && $past(!aux_enable) |-> !aux_pulse);
   // R5
   aux_sel_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      use_aux_ref && !aux_enable && $past(!aux_enable) |-> !tx_cmp_pulse && !rx_cmp_pulse);
   // R10
   mcu_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !osc_tick |=> $stable(mcu_clk_out));
endmodule

bind dual_loop_divider dld_chk u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .osc_tick     (osc_tick),
   .tx_rf_tick   (tx_rf_tick),
   .rx_rf_tick   (rx_rf_tick),
   .aux_enable   (aux_enable),
   .use_aux_ref  (use_aux_ref),
   .tx_sleep     (tx_sleep),
   .rx_sleep     (rx_sleep),
   .aux_pulse    (aux_pulse),
   .tx_cmp_pulse (tx_cmp_pulse),
   .rx_cmp_pulse (rx_cmp_pulse),
   .tx_fb_pulse  (tx_fb_pulse),
   .rx_fb_pulse  (rx_fb_pulse),
   .mcu_clk_out  (mcu_clk_out)
);

// File: tb/dual_loop_divider_test.sv
module dual_loop_divider_test;
   logic clk = 1'b0;
   always #10 clk = ~clk;

   logic        rst_n, osc_tick, tx_rf_tick, rx_rf_tick;
   logic [11:0] tx_ref_ratio, rx_ref_ratio;
   logic [13:0] aux_ratio;
   logic        aux_enable, use_aux_ref;
   logic [15:0] tx_fb_ratio, rx_fb_ratio;
   logic        tx_sleep, rx_sleep, mcu_ratio4;
   logic        tx_cmp_pulse, rx_cmp_pulse, tx_fb_pulse, rx_fb_pulse, mcu_clk_out;

   dual_loop_divider uut (
      .clk(clk), .rst_n(rst_n), .osc_tick(osc_tick), .tx_rf_tick(tx_rf_tick),
      .rx_rf_tick(rx_rf_tick), .tx_ref_ratio(tx_ref_ratio), .rx_ref_ratio(rx_ref_ratio),
      .aux_ratio(aux_ratio), .aux_enable(aux_enable), .use_aux_ref(use_aux_ref),
      .tx_fb_ratio(tx_fb_ratio), .rx_fb_ratio(rx_fb_ratio), .tx_sleep(tx_sleep),
      .rx_sleep(rx_sleep), .mcu_ratio4(mcu_ratio4), .tx_cmp_pulse(tx_cmp_pulse),
      .rx_cmp_pulse(rx_cmp_pulse), .tx_fb_pulse(tx_fb_pulse), .rx_fb_pulse(rx_fb_pulse),
      .mcu_clk_out(mcu_clk_out)
   );

   typedef struct {
      int    ticks;
      string req;
   } item_t;

   // channels: 0 tx_cmp, 1 rx_cmp, 2 tx_fb, 3 rx_fb
   item_t q0[$], q1[$], q2[$], q3[$];
   int    tick [4];
   int    qhits[4];
   bit    quiet[4];
   int    compared   = 0;
   int    mismatched = 0;
   bit    gate_tx    = 1'b0;
   bit    osc_stop   = 1'b0;
   int    gcnt       = 0;

   task automatic summary();
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
   endtask

   task automatic check(bit ok, string req, string what, int act, int exp);
      compared++;
      if (!ok) begin
         mismatched++;
         $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   task automatic push(int ch, int n, int t, string req);
      item_t it;
      it.ticks = t;
      it.req   = req;
      repeat (n) begin
         case (ch)
            0: q0.push_back(it);
            1: q1.push_back(it);
            2: q2.push_back(it);
            default: q3.push_back(it);
         endcase
      end
   endtask

   function automatic int qsize(int ch);
      case (ch)
         0: return q0.size();
         1: return q1.size();
         2: return q2.size();
         default: return q3.size();
      endcase
   endfunction

   function automatic item_t qpop(int ch);
      case (ch)
         0: return q0.pop_front();
         1: return q1.pop_front();
         2: return q2.pop_front();
         default: return q3.pop_front();
      endcase
   endfunction

   function automatic bit held(int ch);
      case (ch)
         0: return tx_sleep || (use_aux_ref && !aux_enable);
         1: return rx_sleep || (use_aux_ref && !aux_enable);
         2: return tx_sleep;
         default: return rx_sleep;
      endcase
   endfunction

   function automatic bit en_of(int ch);
      case (ch)
         0, 1: return osc_tick;
         2: return tx_rf_tick;
         default: return rx_rf_tick;
      endcase
   endfunction

   function automatic bit pulse_of(int ch);
      case (ch)
         0: return tx_cmp_pulse;
         1: return rx_cmp_pulse;
         2: return tx_fb_pulse;
         default: return rx_fb_pulse;
      endcase
   endfunction

   // monitor: counts enabled ticks per channel, compares intervals at each pulse
   initial begin
      for (int ch = 0; ch < 4; ch++) begin
         tick[ch]  = 0;
         qhits[ch] = 0;
         quiet[ch] = 1'b0;
      end
      forever begin
         @(posedge clk);
         for (int ch = 0; ch < 4; ch++) begin
            if (!rst_n || held(ch)) tick[ch] = 0;
            else if (en_of(ch)) tick[ch]++;
         end
         #10;
         for (int ch = 0; ch < 4; ch++) begin
            if (pulse_of(ch)) begin
               if (quiet[ch]) qhits[ch]++;
               if (qsize(ch) > 0) begin
                  item_t it;
                  it = qpop(ch);
                  check(tick[ch] == it.ticks, it.req, $sformatf("ch%0d interval", ch),
                        tick[ch], it.ticks);
               end
               tick[ch] = 0;
            end
         end
      end
   end

   // enable generator
   initial begin
      osc_tick = 1'b1; tx_rf_tick = 1'b1; rx_rf_tick = 1'b1;
      forever begin
         @(posedge clk);
         #4;
         gcnt++;
         osc_tick   = !osc_stop;
         tx_rf_tick = gate_tx ? (gcnt % 3 != 0) : 1'b1;
         rx_rf_tick = 1'b1;
      end
   end

   initial begin
      repeat (150000) @(posedge clk);
      mismatched++;
      $display("FAIL watchdog (all requirements) actual=timeout expected=completion");
      summary();
      $finish;
   end

   task automatic step(int n);
      repeat (n) begin
         @(posedge clk);
         #5;
      end
   endtask

   task automatic drain(int limit);
      int n = 0;
      while ((q0.size() + q1.size() + q2.size() + q3.size()) > 0 && n < limit) begin
         step(1);
         n++;
      end
      for (int ch = 0; ch < 4; ch++) begin
         while (qsize(ch) > 0) begin
            item_t it;
            it = qpop(ch);
            mismatched++;
            compared++;
            $display("FAIL %s ch%0d actual=no pulse expected=%0d ticks", it.req, ch, it.ticks);
         end
      end
   endtask

   task automatic quiesce();
      tx_sleep   = 1'b1;
      rx_sleep   = 1'b1;
      aux_enable = 1'b0;
      step(3);
   endtask

   task automatic wake(bit aux_on);
      tx_sleep   = 1'b0;
      rx_sleep   = 1'b0;
      aux_enable = aux_on;
   endtask

   initial begin
      int highs, rises, v;
      bit prev, stable;
      rst_n = 1'b0; tx_sleep = 1'b0; rx_sleep = 1'b0; aux_enable = 1'b0;
      use_aux_ref = 1'b0; mcu_ratio4 = 1'b0;
      tx_ref_ratio = 12'd20; rx_ref_ratio = 12'd33; aux_ratio = 14'd40;
      tx_fb_ratio = 16'd100; rx_fb_ratio = 16'd257;
      step(4);
      // R1: reset state
      check({tx_cmp_pulse, rx_cmp_pulse, tx_fb_pulse, rx_fb_pulse, mcu_clk_out} == 5'b0,
            "R1", "outputs in reset",
            int'({tx_cmp_pulse, rx_cmp_pulse, tx_fb_pulse, rx_fb_pulse, mcu_clk_out}), 0);

      // R2 independent reference loops, R3 feedback dividers
      push(0, 5, 20, "R2"); push(1, 3, 33, "R2");
      push(2, 2, 100, "R3"); push(3, 1, 257, "R3");
      rst_n = 1'b1;
      drain(3000);

      // R6 clamp, plus top-end reference ratio (R2)
      quiesce();
      tx_ref_ratio = 12'd3; tx_fb_ratio = 16'd0; rx_fb_ratio = 16'd16; rx_ref_ratio = 12'd4095;
      push(0, 3, 16, "R6"); push(2, 3, 16, "R6"); push(3, 2, 16, "R6");
      push(1, 1, 4095, "R2");
      wake(1'b0);
      drain(6000);

      // R7 ratio change mid-period
      quiesce();
      tx_fb_ratio = 16'd20; rx_ref_ratio = 12'd40;
      push(2, 1, 20, "R7"); push(2, 2, 30, "R7");
      push(1, 1, 40, "R7"); push(1, 2, 17, "R7");
      wake(1'b0);
      step(5);
      tx_fb_ratio = 16'd30; rx_ref_ratio = 12'd17;
      drain(500);

      // R8 gated feedback enable
      quiesce();
      gate_tx = 1'b1;
      tx_fb_ratio = 16'd25;
      push(2, 3, 25, "R8");
      wake(1'b0);
      drain(1000);
      gate_tx = 1'b0;

      // R4 auxiliary reference drives both loops
      quiesce();
      use_aux_ref = 1'b1; aux_ratio = 14'd40; tx_ref_ratio = 12'd20; rx_ref_ratio = 12'd33;
      push(0, 3, 40, "R4"); push(1, 3, 40, "R4");
      wake(1'b1);
      drain(500);
      quiesce();
      aux_ratio = 14'd16383;
      push(0, 1, 16383, "R4");
      wake(1'b1);
      drain(17000);

      // R5 auxiliary powered down, then restarted
      quiesce();
      aux_ratio = 14'd40;
      wake(1'b0);
      qhits[0] = 0; qhits[1] = 0; quiet[0] = 1'b1; quiet[1] = 1'b1;
      step(200);
      quiet[0] = 1'b0; quiet[1] = 1'b0;
      check(qhits[0] + qhits[1] == 0, "R5", "pulses while aux off", qhits[0] + qhits[1], 0);
      push(0, 2, 40, "R5"); push(1, 2, 40, "R5");
      aux_enable = 1'b1;
      drain(500);

      // R9 per-loop sleep
      quiesce();
      use_aux_ref = 1'b0; tx_ref_ratio = 12'd20; tx_fb_ratio = 16'd30; rx_fb_ratio = 16'd50;
      wake(1'b0);
      step(100);
      tx_sleep = 1'b1;
      step(1);
      qhits[0] = 0; qhits[2] = 0; quiet[0] = 1'b1; quiet[2] = 1'b1;
      push(3, 3, 50, "R9");
      step(200);
      quiet[0] = 1'b0; quiet[2] = 1'b0;
      check(qhits[0] + qhits[2] == 0, "R9", "tx pulses while asleep", qhits[0] + qhits[2], 0);
      drain(200);
      push(0, 2, 20, "R9"); push(2, 2, 30, "R9");
      tx_sleep = 1'b0;
      drain(500);

      // R10 companion clock
      mcu_ratio4 = 1'b0;
      step(10);
      highs = 0; rises = 0; prev = mcu_clk_out;
      for (int i = 0; i < 12; i++) begin
         step(1);
         if (mcu_clk_out) highs++;
         if (mcu_clk_out && !prev) rises++;
         prev = mcu_clk_out;
      end
      check(highs == 4, "R10", "div3 high count", highs, 4);
      check(rises == 4, "R10", "div3 rising count", rises, 4);
      mcu_ratio4 = 1'b1;
      step(10);
      highs = 0; rises = 0; prev = mcu_clk_out;
      for (int i = 0; i < 12; i++) begin
         step(1);
         if (mcu_clk_out) highs++;
         if (mcu_clk_out && !prev) rises++;
         prev = mcu_clk_out;
      end
      check(highs == 6, "R10", "div4 high count", highs, 6);
      check(rises == 3, "R10", "div4 rising count", rises, 3);
      osc_stop = 1'b1;
      step(2);
      v = int'(mcu_clk_out); stable = 1'b1;
      for (int i = 0; i < 20; i++) begin
         step(1);
         if (int'(mcu_clk_out) != v) stable = 1'b0;
      end
      check(stable, "R10", "hold without osc tick", int'(stable), 1);
      osc_stop = 1'b0;
      step(5);

      summary();
      $finish;
   end
endmodule